// File: doc/BRIEF.md
# Serial Time-Slot Interchange Switch

This block routes byte channels between framed serial links. It has `NSTREAM` serial input lines and `NSTREAM` serial output lines. Each line carries `NCHAN` eight-bit channels per frame, sent MSB first. Every output channel has its own connection entry. The entry either names a source (input line and channel), or makes the channel send a fixed byte that the processor has stored. Each received byte is kept for one frame in a double-buffered data store. Any output channel can therefore take any input channel of the previous frame, whatever the channel order.

One clock drives the block, and each serial bit cell lasts `BIT_DIV` of its cycles. A frame-start pulse moves the timing back to channel 0, bit 0. A small parallel processor port reaches three things:
- a control register;
- the per-output connection entries, each with a low byte and a high byte;
- the received bytes, read-only.

The serial lines run without pause and cannot be held back, so the block has no valid/ready back-pressure. Each output line has its own drive-enable pin. The block also has one global output-enable input and one serial control output.

Top module: `tsi_switch`

## Requirements
- R1: A frame is `NCHAN` channels × 8 bits × `BIT_DIV` clocks. Timing runs freely from reset. When `fp_i` is high at a clock edge, that edge starts a new frame at channel 0, bit 0, first clock of the bit cell.
- R2: Each input line is sampled on the last clock of every bit cell. The first bit of a channel is that byte's MSB.
- R3: Switched mode gives this timing. During frame N+1, output line s, channel c sends the byte that the source line and channel received in frame N. Low entry bits [CW-1:0] select the source channel and bits [SW+CW-1:CW] select the source line. Bits are sent MSB first, and `so_o` shows the bit of each position one clock after that position.
- R4: High entry bit 1 selects message mode. An output channel in message mode sends its 8-bit low entry in place of switched data.
- R5: High entry bit 0 enables a channel. When it is clear, `soe_o` is low and `so_o` is 0 for that line through the whole slot.
- R6: While `ode_i` is low, all `soe_o` and `so_o` bits are 0, starting one clock later, whatever the entries hold.
- R7: `ctl_o` carries high entry bit 2. During bit b of channel c it holds the bit of output line b, channel c. Bit cells b ≥ `NSTREAM` carry 0.
- R8: Address MSB 0 is the control register. Its bits [SW-1:0] select a line, and bits [7:6] select a store: 00 data, 01 low entry, 10 high entry, 11 data. Address MSB 1 accesses channel `addr_i[CW-1:0]` of the selected line in the selected store.
- R9: A data-store read returns the byte that channel received in the most recently completed frame. Writes to the data store are ignored.
- R10: High-entry reads return 0 in bits [7:3]. Control register reads return 0 in the unused bits between the line field and bit 6.
- R11: An access is any clock edge with `cs_i` high; writes take effect at that edge. `ack_o` is high on the next clock. `rdata_o` then holds the read value, or 0 after a write.
- R12: After reset: all outputs are 0, all connection entries and the control register are 0, and so every output channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `BIT_DIV` cycles per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame-start pulse |
| si_i | input | NSTREAM | Serial input lines |
| so_o | output | NSTREAM | Serial output lines |
| soe_o | output | NSTREAM | Per-line drive enable for the current slot |
| ctl_o | output | 1 | Serial control output |
| ode_i | input | 1 | Global output enable |
| cs_i | input | 1 | Processor access strobe |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | CW+1 | Processor address |
| wdata_i | input | 8 | Processor write data |
| rdata_o | output | 8 | Processor read data |
| ack_o | output | 1 | Access acknowledge |

## Verification
Assertions check these on every cycle:
- realignment on the frame pulse;
- the buffer swap at each frame end;
- quiet outputs while `ode_i` is low, and no data driven on a disabled line;
- the acknowledge timing;
- the zero padding of high-entry reads.

Only the bench scenarios can show the rest:
- the one-frame delay and exact bit position of switched bytes;
- message bytes and the control-bit sequence;
- data-store readback, and that data-store writes are ignored.

The bench sweeps every bit of every channel on every line over several frames, including after a realignment part-way through a frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_DATA2 = 2'd3
  } sel_e;

  // per output channel high entry: bit2 control, bit1 message, bit0 enable
  typedef struct packed {
    logic ctl;
    logic msg;
    logic en;
  } chi_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase #(
  parameter int NCHAN   = 32,
  parameter int BIT_DIV = 4,
  localparam int CW = $clog2(NCHAN),
  localparam int PW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_i,
  output logic          smp_o,
  output logic [2:0]    bt_o,
  output logic [CW-1:0] ch_o,
  output logic          bank_o
);

  logic [PW-1:0] ph_q;
  logic [2:0]    bt_q;
  logic [CW-1:0] ch_q;
  logic          bank_q;
  logic          ph_end, bit_end, frm_end;

  assign ph_end  = (ph_q == PW'(BIT_DIV - 1));
  assign bit_end = ph_end && (bt_q == 3'd7);
  assign frm_end = bit_end && (ch_q == CW'(NCHAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bt_q   <= '0;
      ch_q   <= '0;
      bank_q <= 1'b0;
    end else if (fp_i) begin
      ph_q   <= '0;
      bt_q   <= '0;
      ch_q   <= '0;
      bank_q <= ~bank_q;
    end else begin
      ph_q <= ph_end ? '0 : ph_q + 1'b1;
      if (ph_end) bt_q <= bt_q + 3'd1;
      if (bit_end) ch_q <= frm_end ? '0 : ch_q + 1'b1;
      if (frm_end) bank_q <= ~bank_q;
    end
  end

  assign smp_o  = ph_end;
  assign bt_o   = bt_q;
  assign ch_o   = ch_q;
  assign bank_o = bank_q;

  assert_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (ch_o == '0 && bt_o == 3'd0 && ph_q == '0));

  assert_frame_swap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_i && frm_end) |=> (bank_o != $past(bank_o)));

endmodule

// File: rtl/tsi_capture.sv
module tsi_capture #(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  localparam int SW  = $clog2(NSTREAM),
  localparam int CW  = $clog2(NCHAN),
  localparam int AIW = SW + CW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSTREAM-1:0]            si_i,
  input  logic                          smp_i,
  input  logic [2:0]                    bt_i,
  input  logic [CW-1:0]                 ch_i,
  input  logic                          bank_i,
  input  logic [NSTREAM-1:0][AIW-1:0]   tx_src_i,
  output logic [NSTREAM-1:0][7:0]       tx_byte_o,
  input  logic [AIW-1:0]                cpu_src_i,
  output logic [7:0]                    cpu_byte_o
);

  localparam int DEPTH = 2 * NSTREAM * NCHAN;

  logic [7:0]               mem [DEPTH];
  logic [NSTREAM-1:0][7:0]  shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (smp_i) begin
      for (int s = 0; s < NSTREAM; s++)
        shift_q[s] <= {shift_q[s][6:0], si_i[s]};
    end
  end

  // completed byte lands in the bank of the frame it arrived in
  always_ff @(posedge clk) begin
    if (smp_i && bt_i == 3'd7) begin
      for (int s = 0; s < NSTREAM; s++)
        mem[{bank_i, SW'(s), ch_i}] <= {shift_q[s][6:0], si_i[s]};
    end
  end

  // both readers see only the bank of the previous frame
  for (genvar s = 0; s < NSTREAM; s++) begin : g_rd
    assign tx_byte_o[s] = mem[{~bank_i, tx_src_i[s]}];
  end
  assign cpu_byte_o = mem[{~bank_i, cpu_src_i}];

endmodule

// File: rtl/tsi_connmem.sv
module tsi_connmem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  localparam int SW  = $clog2(NSTREAM),
  localparam int CW  = $clog2(NCHAN),
  localparam int AIW = SW + CW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_lo_i,
  input  logic                      we_hi_i,
  input  logic [AIW-1:0]            cpu_addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                cpu_lo_o,
  output chi_t                      cpu_hi_o,
  input  logic [CW-1:0]             ch_i,
  output logic [NSTREAM-1:0][7:0]   lo_o,
  output chi_t [NSTREAM-1:0]        hi_o
);

  localparam int N = NSTREAM * NCHAN;

  logic [7:0] lo_q [N];
  chi_t       hi_q [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else begin
      if (we_lo_i) lo_q[cpu_addr_i] <= wdata_i;
      if (we_hi_i) hi_q[cpu_addr_i] <= chi_t'(wdata_i[2:0]);
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_tx
    assign lo_o[s] = lo_q[{SW'(s), ch_i}];
    assign hi_o[s] = hi_q[{SW'(s), ch_i}];
  end

  assign cpu_lo_o = lo_q[cpu_addr_i];
  assign cpu_hi_o = hi_q[cpu_addr_i];

  assert_single_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_lo_i && we_hi_i));

endmodule

// File: rtl/tsi_emit.sv
module tsi_emit
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  localparam int SW = $clog2(NSTREAM)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ode_i,
  input  logic [2:0]                bt_i,
  input  logic [NSTREAM-1:0][7:0]   lo_i,
  input  chi_t [NSTREAM-1:0]        hi_i,
  input  logic [NSTREAM-1:0][7:0]   dm_i,
  output logic [NSTREAM-1:0]        so_o,
  output logic [NSTREAM-1:0]        soe_o,
  output logic                      ctl_o
);

  logic [NSTREAM-1:0] bit_d, en_d;
  logic               ctl_d;

  always_comb begin
    for (int s = 0; s < NSTREAM; s++) begin
      en_d[s]  = ode_i & hi_i[s].en;
      // ~bt_i picks bit 7 first: MSB-first order
      bit_d[s] = en_d[s] & (hi_i[s].msg ? lo_i[s][~bt_i] : dm_i[s][~bt_i]);
    end
    ctl_d = (int'(bt_i) < NSTREAM) ? hi_i[bt_i[SW-1:0]].ctl : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so_o  <= '0;
      soe_o <= '0;
      ctl_o <= 1'b0;
    end else begin
      so_o  <= bit_d;
      soe_o <= en_d;
      ctl_o <= ctl_d;
    end
  end

  assert_global_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ode_i |=> (soe_o == '0 && so_o == '0));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_o & ~soe_o) == '0);

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int BIT_DIV = 4,
  localparam int SW  = $clog2(NSTREAM),
  localparam int CW  = $clog2(NCHAN),
  localparam int AIW = SW + CW,
  localparam int AW  = CW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fp_i,
  input  logic [NSTREAM-1:0] si_i,
  output logic [NSTREAM-1:0] so_o,
  output logic [NSTREAM-1:0] soe_o,
  output logic               ctl_o,
  input  logic               ode_i,
  input  logic               cs_i,
  input  logic               rw_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               ack_o
);

  logic                         smp, bank;
  logic [2:0]                   bt;
  logic [CW-1:0]                ch;
  logic [NSTREAM-1:0][AIW-1:0]  tx_src;
  logic [NSTREAM-1:0][7:0]      tx_byte, lo_tx;
  chi_t [NSTREAM-1:0]           hi_tx;
  logic [7:0]                   cpu_dm, cpu_lo;
  chi_t                         cpu_hi;

  sel_e            sel_q;
  logic [SW-1:0]   str_q;
  logic            is_chan, we_lo, we_hi, wr_ctrl;
  logic [AIW-1:0]  cpu_src;
  logic [7:0]      rd_val;

  tsi_timebase #(.NCHAN(NCHAN), .BIT_DIV(BIT_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i),
    .smp_o(smp), .bt_o(bt), .ch_o(ch), .bank_o(bank)
  );

  for (genvar s = 0; s < NSTREAM; s++) begin : g_src
    assign tx_src[s] = lo_tx[s][AIW-1:0];
  end

  tsi_capture #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_cap (
    .clk(clk), .rst_n(rst_n), .si_i(si_i), .smp_i(smp), .bt_i(bt),
    .ch_i(ch), .bank_i(bank), .tx_src_i(tx_src), .tx_byte_o(tx_byte),
    .cpu_src_i(cpu_src), .cpu_byte_o(cpu_dm)
  );

  tsi_connmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN)) u_cm (
    .clk(clk), .rst_n(rst_n), .we_lo_i(we_lo), .we_hi_i(we_hi),
    .cpu_addr_i(cpu_src), .wdata_i(wdata_i), .cpu_lo_o(cpu_lo),
    .cpu_hi_o(cpu_hi), .ch_i(ch), .lo_o(lo_tx), .hi_o(hi_tx)
  );

  tsi_emit #(.NSTREAM(NSTREAM)) u_em (
    .clk(clk), .rst_n(rst_n), .ode_i(ode_i), .bt_i(bt), .lo_i(lo_tx),
    .hi_i(hi_tx), .dm_i(tx_byte), .so_o(so_o), .soe_o(soe_o), .ctl_o(ctl_o)
  );

  // processor port decode
  assign is_chan = addr_i[AW-1];
  assign cpu_src = {str_q, addr_i[CW-1:0]};
  assign wr_ctrl = cs_i && !rw_i && !is_chan;
  assign we_lo   = cs_i && !rw_i && is_chan && (sel_q == SEL_LOW);
  assign we_hi   = cs_i && !rw_i && is_chan && (sel_q == SEL_HIGH);

  always_comb begin
    if (!is_chan) begin
      rd_val = {sel_q, {(6-SW){1'b0}}, str_q};
    end else begin
      unique case (sel_q)
        SEL_LOW:  rd_val = cpu_lo;
        SEL_HIGH: rd_val = {5'b0, cpu_hi};
        default:  rd_val = cpu_dm;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= SEL_DATA;
      str_q   <= '0;
      rdata_o <= '0;
      ack_o   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= sel_e'(wdata_i[7:6]);
        str_q <= wdata_i[SW-1:0];
      end
      rdata_o <= (cs_i && rw_i) ? rd_val : 8'h00;
      ack_o   <= cs_i;
    end
  end

  assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_i |=> ack_o);

  assert_ack_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !ack_o);

  assert_write_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !rw_i) |=> (rdata_o == 8'h00));

  assert_high_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && rw_i && is_chan && sel_q == SEL_HIGH) |=> (rdata_o[7:3] == 5'b0));

endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;

  localparam int NS  = 4;
  localparam int NC  = 8;
  localparam int D   = 2;
  localparam int FRM = NC * 8 * D;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fp = 1'b0;
  logic [NS-1:0] si = '0;
  logic [NS-1:0] so_o, soe_o;
  logic          ctl_o;
  logic          ode = 1'b1;
  logic          cs = 1'b0, rw = 1'b1;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata_o;
  logic          ack_o;

  int vecs = 0;
  int miss = 0;

  always #5 clk = ~clk;

  tsi_switch #(.NSTREAM(NS), .NCHAN(NC), .BIT_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .fp_i(fp), .si_i(si), .so_o(so_o),
    .soe_o(soe_o), .ctl_o(ctl_o), .ode_i(ode), .cs_i(cs), .rw_i(rw),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .ack_o(ack_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      miss++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // routing table chosen arithmetically
  function automatic int ix(int s, int c);       return s * NC + c;              endfunction
  function automatic bit is_msg(int s, int c);   return (ix(s, c) % 5) == 0;     endfunction
  function automatic bit is_en(int s, int c);    return (ix(s, c) % 7) != 3;     endfunction
  function automatic bit is_ctl(int s, int c);   return (ix(s, c) % 3) == 0;     endfunction
  function automatic int src_s(int s, int c);    return (s + c) % NS;            endfunction
  function automatic int src_c(int s, int c);    return (c * 3 + s + 1) % NC;    endfunction
  function automatic logic [7:0] msg_b(int s, int c); return 8'(ix(s, c) * 37 + 5); endfunction
  function automatic logic [7:0] low_v(int s, int c);
    return is_msg(s, c) ? msg_b(s, c) : 8'(src_s(s, c) * NC + src_c(s, c));
  endfunction
  function automatic logic [7:0] hi_v(int s, int c);
    return {5'b0, is_ctl(s, c), is_msg(s, c), is_en(s, c)};
  endfunction
  function automatic logic [7:0] pat(int f, int s, int c, int seed);
    return 8'(f * 53 + s * 29 + c * 11 + 7 + seed);
  endfunction

  task automatic cpu(input logic r, input logic [3:0] a, input logic [7:0] wd,
                     output logic [7:0] rd);
    @(negedge clk);
    cs = 1'b1; rw = r; addr = a; wdata = wd;
    @(negedge clk);
    cs = 1'b0;
    rd = rdata_o;
    check("R11 ack", int'(ack_o), 1);
    if (!r) check("R11 write rdata", int'(rdata_o), 0);
  endtask

  // one frame pulse, then nf frames driven and every position checked
  task automatic run(input int nf, input int seed, input int off_f);
    @(negedge clk);
    fp = 1'b1;
    for (int k = 0; k <= nf * FRM; k++) begin
      @(negedge clk);
      fp = 1'b0;
      if (k > 0) begin
        int p = k - 1;
        int f = p / FRM;
        int c = (p % FRM) / (8 * D);
        int b = ((p % FRM) / D) % 8;
        bit od = (f != off_f);
        for (int s = 0; s < NS; s++) begin
          bit e = od && is_en(s, c);
          logic [7:0] byt;
          check(od ? "R5 enable" : "R6 enable", int'(soe_o[s]), int'(e));
          if (is_msg(s, c)) begin
            byt = msg_b(s, c);
            check("R4 message bit", int'(so_o[s]), e ? int'(byt[7-b]) : 0);
          end else if (f >= 1) begin
            // R2 capture order and R3 one-frame delay together
            byt = pat(f - 1, src_s(s, c), src_c(s, c), seed);
            check("R3 switched bit", int'(so_o[s]), e ? int'(byt[7-b]) : 0);
          end
        end
        check("R7 control bit", int'(ctl_o), (b < NS) ? int'(is_ctl(b, c)) : 0);
      end
      if (k < nf * FRM) begin
        int f = k / FRM;
        int c = (k % FRM) / (8 * D);
        int b = ((k % FRM) / D) % 8;
        for (int s = 0; s < NS; s++) begin
          logic [7:0] byt = pat(f, s, c, seed);
          si[s] = byt[7-b];
        end
        ode = (f != off_f);
      end
    end
  endtask

  initial begin
    #2_000_000;
    vecs++;
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state, with ode high and entries cleared
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R12 so", int'(so_o), 0);
      check("R12 soe", int'(soe_o), 0);
      check("R12 ctl", int'(ctl_o), 0);
      check("R12 ack", int'(ack_o), 0);
      check("R12 rdata", int'(rdata_o), 0);
    end
    cpu(1'b1, 4'h0, 8'h00, rd);
    check("R12 control reg", int'(rd), 0);

    // program entries: upper bits of high writes must read back as 0
    for (int s = 0; s < NS; s++) begin
      cpu(1'b0, 4'h0, 8'(8'h40 | s), rd);
      for (int c = 0; c < NC; c++) cpu(1'b0, 4'(8 | c), low_v(s, c), rd);
      cpu(1'b0, 4'h0, 8'(8'h80 | s), rd);
      for (int c = 0; c < NC; c++) cpu(1'b0, 4'(8 | c), hi_v(s, c) | 8'hF8, rd);
    end
    for (int s = 0; s < NS; s++) begin
      cpu(1'b0, 4'h0, 8'(8'h40 | s), rd);
      for (int c = 0; c < NC; c++) begin
        cpu(1'b1, 4'(8 | c), 8'h00, rd);
        check("R8 low readback", int'(rd), int'(low_v(s, c)));
      end
      cpu(1'b0, 4'h0, 8'(8'h80 | s), rd);
      for (int c = 0; c < NC; c++) begin
        cpu(1'b1, 4'(8 | c), 8'h00, rd);
        check("R10 high readback", int'(rd), int'(hi_v(s, c)));
      end
    end

    // five frames, outputs globally off in frame 3
    run(5, 0, 3);

    // frame 4 is the last completed frame now
    cpu(1'b0, 4'h0, 8'hFF, rd);
    cpu(1'b1, 4'h0, 8'h00, rd);
    check("R10 control pad", int'(rd), 8'hC3);
    cpu(1'b1, 4'(8 | 5), 8'h00, rd);
    check("R8 alias store", int'(rd), int'(pat(4, 3, 5, 0)));
    cpu(1'b0, 4'h0, 8'h00, rd);
    cpu(1'b0, 4'(8 | 2), 8'hAA, rd);
    for (int s = 0; s < NS; s++) begin
      cpu(1'b0, 4'h0, 8'(s), rd);
      for (int c = 0; c < NC; c++) begin
        cpu(1'b1, 4'(8 | c), 8'h00, rd);
        check("R9 data read", int'(rd), int'(pat(4, s, c, 0)));
      end
    end

    // realign part-way through a frame (R1), then check again
    repeat (37) @(negedge clk);
    run(3, 101, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule